// File: doc/BRIEF.md
# Quadrature to count-pulse converter

This block sits between an incremental encoder and an up/down counter. It samples the encoder's two phase signals on the system clock and passes each through a synchroniser and a settle filter. It then works out the direction of every accepted step and turns the steps into ready-made, active-low counter clocks. Two forms come out at the same time. One form has a separate up clock and down clock. The other has a single combined clock with a direction level beside it.

A mode pin chooses between one pulse per filtered edge and one pulse per full quadrature cycle. The low time of each pulse is set in clock cycles by an input bus. A step that arrives while a pulse is still low is held in a single pending slot. It is issued after one high cycle, so that a counter clocked on the rising edge sees every pulse separately.

Top module: `quad_pulse_conv`

## Requirements
- R1: After reset, `up_clk_n`, `dn_clk_n` and `cnt_clk_n` are high, `dir_up` is high and `step_err` is low.
- R2: A new level on either phase is accepted only after it has been seen for FILT_LEN (default 3) consecutive synchronised samples. A shorter glitch produces no pulse. A level held exactly FILT_LEN samples is accepted.
- R3: With `x4_sel` high, every accepted single-phase transition produces exactly one pulse.
- R4: The state order (A,B) = 00, 10, 11, 01, 00 (A leads B) counts up, and the reverse order counts down. Up pulses appear only on `up_clk_n`, down pulses only on `dn_clk_n`, and the two are never low together.
- R5: With `x4_sel` low, an up pulse is produced only when A rises while B is low (00 to 10), and a down pulse only when A falls while B is low (10 to 00). No other transition produces a pulse.
- R6: `cnt_clk_n` pulses low for every up and every down pulse. While it is low, `dir_up` is high for an up pulse and low for a down pulse.
- R7: `dir_up` changes only at the cycle a pulse starts, and it is unchanged across the rising edge of `cnt_clk_n`.
- R8: Each pulse stays low for exactly `pulse_width` cycles, or 1 cycle when `pulse_width` is 0. The value is taken in the cycle the pulse starts.
- R9: A sample in which both filtered phases change at once produces no pulse and raises `step_err` for exactly one cycle.
- R10: A step accepted while a pulse is low is stored in a one-deep pending slot. It is emitted, with its own direction, after exactly one high cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample and logic clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phase_a | input | 1 | Encoder phase A, asynchronous |
| phase_b | input | 1 | Encoder phase B, asynchronous |
| x4_sel | input | 1 | 1: pulse per edge, 0: pulse per quadrature cycle |
| pulse_width | input | PW_W | Low time of each output pulse in clock cycles |
| up_clk_n | output | 1 | Active-low up count clock |
| dn_clk_n | output | 1 | Active-low down count clock |
| cnt_clk_n | output | 1 | Active-low combined count clock |
| dir_up | output | 1 | Direction for the combined clock, 1 = up |
| step_err | output | 1 | One-cycle strobe on an illegal double step |

## Verification
The bench targets the filter boundary. A glitch one sample shorter than the filter length must vanish, and one exactly as long must count. A design off by one in its filter would either count dither or drop real edges. In per-cycle mode, repeated reversals across the 00/10 boundary check that a design with no fixed decode phase does not drift or count the same edge twice. Steps closer together than the pulse width exercise the pending slot: a design without it loses counts, and one without a high gap merges two pulses into one rising edge. A double step must leave every count unchanged, while a zero width must still give a one-cycle pulse.

// File: rtl/quad_pulse_conv.sv
module quad_pulse_conv #(
  parameter int FILT_LEN = 3,
  parameter int PW_W     = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            phase_a,
  input  logic            phase_b,
  input  logic            x4_sel,
  input  logic [PW_W-1:0] pulse_width,
  output logic            up_clk_n,
  output logic            dn_clk_n,
  output logic            cnt_clk_n,
  output logic            dir_up,
  output logic            step_err
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic [1:0] raw, s1, s2, filt, prev;
  logic       fv [2];

  assign raw = {phase_a, phase_b};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= '0;
      s2 <= '0;
    end else begin
      s1 <= raw;
      s2 <= s1;
    end

  for (genvar ch = 0; ch < 2; ch++) begin : g_filt
    logic [CW-1:0] cnt;
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        cnt    <= '0;
        fv[ch] <= 1'b0;
      end else if (s2[ch] == fv[ch]) begin
        cnt <= '0;
      end else if (cnt == CW'(FILT_LEN - 1)) begin
        fv[ch] <= s2[ch];
        cnt    <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
  end

  assign filt = {fv[1], fv[0]};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev <= '0;
    else        prev <= filt;

  logic a_chg, b_chg, one_step, mv_up, x1_hit, ev;
  assign a_chg    = filt[1] ^ prev[1];
  assign b_chg    = filt[0] ^ prev[0];
  assign one_step = a_chg ^ b_chg;
  assign step_err = a_chg & b_chg;
  assign mv_up    = a_chg ? (filt[1] ^ filt[0]) : ~(filt[1] ^ filt[0]);
  assign x1_hit   = a_chg & ~b_chg & ~filt[0];
  assign ev       = x4_sel ? one_step : x1_hit;

  logic [PW_W-1:0] pw_cnt, w_eff;
  logic            pend, pend_up, cur_up, active;

  assign active = |pw_cnt;
  assign w_eff  = (pulse_width == '0) ? PW_W'(1) : pulse_width;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pw_cnt  <= '0;
      pend    <= 1'b0;
      pend_up <= 1'b0;
      cur_up  <= 1'b1;
    end else if (active) begin
      pw_cnt <= pw_cnt - 1'b1;
      if (ev) begin
        pend    <= 1'b1;
        pend_up <= mv_up;
      end
    end else if (pend) begin
      pw_cnt <= w_eff;
      cur_up <= pend_up;
      pend   <= ev;
      if (ev) pend_up <= mv_up;
    end else if (ev) begin
      pw_cnt <= w_eff;
      cur_up <= mv_up;
    end

  assign up_clk_n  = ~(active & cur_up);
  assign dn_clk_n  = ~(active & ~cur_up);
  assign cnt_clk_n = ~active;
  assign dir_up    = cur_up;
endmodule

module quad_pulse_conv_chk #(
  parameter int PW_W = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            up_clk_n,
  input logic            dn_clk_n,
  input logic            cnt_clk_n,
  input logic            dir_up,
  input logic            step_err,
  input logic            pend,
  input logic [PW_W-1:0] pulse_width
);
  logic [PW_W-1:0] pw_prev, exp_w;
  logic [PW_W:0]   lowc;
  logic            prev_c;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pw_prev <= '0;
      exp_w   <= PW_W'(1);
      lowc    <= '0;
      prev_c  <= 1'b1;
    end else begin
      pw_prev <= pulse_width;
      prev_c  <= cnt_clk_n;
      if (prev_c && !cnt_clk_n) begin
        exp_w <= (pw_prev == '0) ? PW_W'(1) : pw_prev;
        lowc  <= (PW_W+1)'(1);
      end else if (!cnt_clk_n) begin
        lowc <= lowc + 1'b1;
      end
    end

  // R4
  up_dn_mutex_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!up_clk_n && !dn_clk_n));

  // R6
  comb_dir_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_clk_n |-> (dir_up == !up_clk_n));

  // R7
  dir_hold_at_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_clk_n && !prev_c) |-> $stable(dir_up));

  // R8
  pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_clk_n && !prev_c) |-> (lowc == {1'b0, exp_w}));

  // R9
  err_no_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_err && cnt_clk_n && !pend) |=> cnt_clk_n);
endmodule

bind quad_pulse_conv quad_pulse_conv_chk #(.PW_W(PW_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .up_clk_n(up_clk_n), .dn_clk_n(dn_clk_n),
  .cnt_clk_n(cnt_clk_n), .dir_up(dir_up), .step_err(step_err),
  .pend(pend), .pulse_width(pulse_width)
);

// File: tb/quad_pulse_conv_bench.sv
module quad_pulse_conv_bench;
  localparam int PW_W = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic pa = 1'b0, pb = 1'b0, x4 = 1'b1;
  logic [PW_W-1:0] pw = 8'd4;
  logic up_clk_n, dn_clk_n, cnt_clk_n, dir_up, step_err;

  always #10 clk = ~clk;

  quad_pulse_conv #(.FILT_LEN(3), .PW_W(PW_W)) u_quad_pulse_conv (
    .clk(clk), .rst_n(rst_n), .phase_a(pa), .phase_b(pb), .x4_sel(x4),
    .pulse_width(pw), .up_clk_n(up_clk_n), .dn_clk_n(dn_clk_n),
    .cnt_clk_n(cnt_clk_n), .dir_up(dir_up), .step_err(step_err)
  );

  int n_chk = 0, n_bad = 0;
  int up_o = 0, dn_o = 0, cu_o = 0, cd_o = 0, err_o = 0, wbad = 0, dbad = 0, both_lo = 0;
  int eu = 0, ed = 0, ee = 0, idx = 0, exp_w = 4, run = 0;
  bit prev_u = 1'b1, prev_d = 1'b1, prev_c = 1'b1, lastdir = 1'b1, done = 1'b0;

  always @(negedge clk) if (rst_n) begin
    if (prev_u && !up_clk_n) up_o++;
    if (prev_d && !dn_clk_n) dn_o++;
    if (!up_clk_n && !dn_clk_n) both_lo++;
    if (!cnt_clk_n) begin
      run++;
      lastdir = dir_up;
    end
    if (!prev_c && cnt_clk_n) begin
      if (lastdir) cu_o++; else cd_o++;
      if (run != exp_w) wbad++;
      if (dir_up != lastdir) dbad++;
      run = 0;
    end
    if (step_err) err_o++;
    prev_u = up_clk_n;
    prev_d = dn_clk_n;
    prev_c = cnt_clk_n;
  end

  task automatic chk(string req, string what, int act, int expv);
    n_chk++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic hold(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic bit gray_a(int i); return (i == 1 || i == 2); endfunction
  function automatic bit gray_b(int i); return (i == 2 || i == 3); endfunction

  task automatic move(bit up, int h);
    int old;
    old = idx;
    idx = up ? (idx + 1) % 4 : (idx + 3) % 4;
    if (x4) begin
      if (up) eu++; else ed++;
    end else begin
      if (old == 0 && idx == 1) eu++;
      if (old == 1 && idx == 0) ed++;
    end
    pa = gray_a(idx);
    pb = gray_b(idx);
    hold(h);
  endtask

  task automatic settle(string req);
    hold(40);
    chk(req, "up_clk_n pulses", up_o, eu);
    chk(req, "dn_clk_n pulses", dn_o, ed);
    chk("R6", "combined up pulses", cu_o, eu);
    chk("R6", "combined down pulses", cd_o, ed);
    chk("R8", "pulse width errors", wbad, 0);
    chk("R7", "dir change at rise", dbad, 0);
    chk("R4", "up and down both low", both_lo, 0);
    chk("R9", "step_err strobes", err_o, ee);
  endtask

  task automatic set_width(int w);
    pw = PW_W'(w);
    exp_w = (w == 0) ? 1 : w;
  endtask

  task automatic summary;
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    void'($urandom(32'd2024));
    hold(3);
    // R1 reset state
    chk("R1", "up_clk_n", int'(up_clk_n), 1);
    chk("R1", "dn_clk_n", int'(dn_clk_n), 1);
    chk("R1", "cnt_clk_n", int'(cnt_clk_n), 1);
    chk("R1", "dir_up", int'(dir_up), 1);
    chk("R1", "step_err", int'(step_err), 0);
    rst_n = 1'b1;
    hold(5);

    // R3 R4 x4 forward and backward
    x4 = 1'b1;
    for (int i = 0; i < 8; i++) move(1'b1, 12);
    settle("R3");
    for (int i = 0; i < 8; i++) move(1'b0, 12);
    settle("R4");

    // R5 x1 both directions and reversals at the decode boundary
    x4 = 1'b0;
    for (int i = 0; i < 8; i++) move(1'b1, 10);
    settle("R5");
    for (int i = 0; i < 8; i++) move(1'b0, 10);
    settle("R5");
    while (idx != 0) move(1'b1, 10);
    for (int i = 0; i < 3; i++) begin
      move(1'b1, 10);
      move(1'b0, 10);
    end
    move(1'b0, 10);
    move(1'b1, 10);
    settle("R5");

    // R2 glitch shorter than the filter, then exactly filter length
    x4 = 1'b1;
    pa = ~pa; hold(2); pa = ~pa; hold(20);
    pb = ~pb; hold(1); pb = ~pb; hold(20);
    settle("R2");
    move(1'b1, 3);
    move(1'b0, 20);
    settle("R2");

    // R9 illegal double step
    idx = (idx + 2) % 4; ee++;
    pa = gray_a(idx); pb = gray_b(idx);
    hold(20);
    settle("R9");
    move(1'b1, 12);
    settle("R9");

    // R8 width zero and wide pulses
    set_width(0);
    for (int i = 0; i < 4; i++) move(1'b0, 8);
    settle("R8");
    set_width(20);
    for (int i = 0; i < 3; i++) move(1'b1, 30);
    settle("R8");

    // R10 pending slot, including a direction change in the slot
    set_width(10);
    move(1'b1, 5);
    move(1'b1, 40);
    settle("R10");
    move(1'b1, 5);
    move(1'b0, 40);
    settle("R10");

    // random walk
    for (int seg = 0; seg < 6; seg++) begin
      x4 = 1'(($urandom % 2));
      set_width(1 + int'($urandom % 6));
      for (int i = 0; i < 50; i++) move(1'($urandom % 2), 8 + int'($urandom % 8));
      settle(x4 ? "R3" : "R5");
    end

    summary();
  end
endmodule